// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block is a synchronous controller that performs single-word writes into an external asynchronous static RAM. The RAM has a low-active and a high-active chip select, a low-active write strobe and a shared data bus. Output enable is tied active for the whole time, so the RAM drives the bus whenever it is selected with the write strobe high. The controller never drives the bus during such a window.

A client offers an address and a data word with a valid/ready handshake. The controller presents the address with every control line idle and waits a setup count. It then lowers the write strobe and, one clock later, selects the RAM with both chip selects together while it drives the data word. The chip selects close the write after an overlap count. The data stays driven for a hold count. The bus is then released and the strobe raised in the same clock, and a recovery count runs before the next request can enter. Each of the four counts is a parameter given in clocks, with a minimum of one. A one-clock done pulse marks the last recovery clock.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is held, and in the first clock after it, the outputs are: ready 1, done 0, write strobe 1, low-active select 1, high-active select 0, output enable 0 and bus drive 0.
- R2: A request is taken on a clock edge where valid and ready are both 1. Ready is 0 from the next clock until the cycle after done.
- R3: The address and data are captured when the request is taken, and the taken word ends up stored at the taken address. The address lines change only in a clock where the write strobe was 1 before and after the change.
- R4: For T_SETUP clocks after acceptance, the new address is presented and the strobe, both selects and the bus drive stay idle.
- R5: The strobe falls exactly one clock before both selects become active. The two selects always switch in the same clock (low-active select = inverse of high-active select). The selects are active only while the strobe is 0.
- R6: The bus is driven only while the strobe is 0, so the controller and the RAM never drive the bus together. Whenever the bus is driven, it carries the captured data word.
- R7: Both selects stay active for exactly T_OVERLAP clocks, and the bus is driven during all of them.
- R8: After the selects release, the bus stays driven and the strobe stays 0 for exactly T_HOLD clocks.
- R9: The strobe then rises in the same clock that the bus is released. T_RECOV idle clocks follow, and done is 1 only in the last of them. Ready is 1 in the next clock.
- R10: A valid request while ready is 0 has no effect: the address lines and the driven data of the write in progress do not change.
- R11: Output enable stays 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, low active |
| req_valid | input | 1 | write request offered |
| req_addr | input | AW | word address of the request |
| req_data | input | DW | data word of the request |
| req_ready | output | 1 | controller can take a request |
| wr_done | output | 1 | one-clock pulse in the last recovery clock |
| sram_addr | output | AW | address lines to the RAM |
| sram_ce1_n | output | 1 | chip select, low active |
| sram_ce2 | output | 1 | chip select, high active |
| sram_we_n | output | 1 | write strobe, low active |
| sram_oe_n | output | 1 | output enable, held low |
| sram_dq_out | output | DW | data driven toward the bus |
| sram_dq_oe | output | 1 | 1 when the controller drives the bus |

## Verification
The hardest case to reach from the ports is a request that arrives while a write is already in flight. It must not disturb the address or the driven data, and it must not slip in at the boundary where ready comes back. The stimulus reaches this case by toggling valid with inverted address and data on random clocks inside a busy window. It drops valid only in the final recovery clock. The bench also issues writes back to back, so that one write's acceptance edge directly follows the previous done. A bench-side RAM model flags any bus conflict or any address change under a low strobe, and it records the stored words, which are compared with the expected contents.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_WEL   = 3'd2,
    PH_OVL   = 3'd3,
    PH_HOLD  = 3'd4,
    PH_RECOV = 3'd5
  } phase_t;

  // clocks spent in a phase
  function automatic int unsigned phase_len(phase_t p, int unsigned ts,
                                            int unsigned tov, int unsigned th,
                                            int unsigned tr);
    case (p)
      PH_SETUP: return ts;
      PH_OVL:   return tov;
      PH_HOLD:  return th;
      PH_RECOV: return tr;
      default:  return 1;
    endcase
  endfunction

  function automatic phase_t phase_next(phase_t p);
    case (p)
      PH_SETUP: return PH_WEL;
      PH_WEL:   return PH_OVL;
      PH_OVL:   return PH_HOLD;
      PH_HOLD:  return PH_RECOV;
      default:  return PH_IDLE;
    endcase
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // busy clocks from the acceptance edge to the last recovery clock
  function automatic int unsigned busy_total(int unsigned ts, int unsigned tov,
                                             int unsigned th, int unsigned tr);
    return ts + 1 + tov + th + tr;
  endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // a running count only moves down by one
  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sram_wr_fsm.sv
module sram_wr_fsm
  import sram_wr_pkg::*;
#(
  parameter int unsigned T_SETUP   = 1,
  parameter int unsigned T_OVERLAP = 2,
  parameter int unsigned T_HOLD    = 1,
  parameter int unsigned T_RECOV   = 1,
  parameter int          CW        = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  output phase_t phase,
  output logic   accept,
  output logic   done
);
  phase_t        nxt;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  logic          phase_end;

  sram_wr_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign accept    = (phase == PH_IDLE) && req_valid;
  assign phase_end = (phase != PH_IDLE) && tmr_expired;
  assign done      = (phase == PH_RECOV) && tmr_expired;

  always_comb begin
    nxt      = phase;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept)         nxt = PH_SETUP;
    else if (phase_end) nxt = phase_next(phase);
    if ((accept || phase_end) && nxt != PH_IDLE) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(phase_len(nxt, T_SETUP, T_OVERLAP, T_HOLD, T_RECOV) - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  assert_accept_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase == PH_SETUP));
  assert_done_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (phase == PH_IDLE));
  assert_strobe_phase_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WEL) |=> (phase == PH_OVL));
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins
  import sram_wr_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        phase,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          ready,
  output logic [AW-1:0] addr,
  output logic          ce1_n,
  output logic          ce2,
  output logic          we_n,
  output logic          oe_n,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          sel_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  always_comb begin
    sel_act = 1'b0;
    we_n    = 1'b1;
    dq_oe   = 1'b0;
    case (phase)
      PH_WEL:  we_n = 1'b0;
      PH_OVL:  begin we_n = 1'b0; sel_act = 1'b1; dq_oe = 1'b1; end
      PH_HOLD: begin we_n = 1'b0; dq_oe = 1'b1; end
      default: ;
    endcase
  end

  assign ce1_n  = ~sel_act;
  assign ce2    = sel_act;
  assign oe_n   = 1'b0;
  assign ready  = (phase == PH_IDLE);
  assign addr   = addr_q;
  assign dq_out = data_q;

  assert_selects_paired_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce1_n == ~ce2);
  assert_select_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce2 |-> !we_n);
  assert_strobe_before_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> $past(!we_n));
  assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);
  assert_addr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> $stable(addr));
  assert_data_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));
  assert_oe_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n);
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int          AW        = 10,
  parameter int          DW        = 16,
  parameter int unsigned T_SETUP   = 1,
  parameter int unsigned T_OVERLAP = 2,
  parameter int unsigned T_HOLD    = 1,
  parameter int unsigned T_RECOV   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic          wr_done,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce1_n,
  output logic          sram_ce2,
  output logic          sram_we_n,
  output logic          sram_oe_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe
);
  localparam int unsigned LEN_MAX = max_of4(T_SETUP, T_OVERLAP, T_HOLD, T_RECOV);
  localparam int          CW      = (LEN_MAX < 2) ? 1 : $clog2(LEN_MAX);

  phase_t phase;
  logic   accept;

  sram_wr_fsm #(
    .T_SETUP(T_SETUP), .T_OVERLAP(T_OVERLAP), .T_HOLD(T_HOLD),
    .T_RECOV(T_RECOV), .CW(CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .phase     (phase),
    .accept    (accept),
    .done      (wr_done)
  );

  sram_wr_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .accept   (accept),
    .req_addr (req_addr),
    .req_data (req_data),
    .ready    (req_ready),
    .addr     (sram_addr),
    .ce1_n    (sram_ce1_n),
    .ce2      (sram_ce2),
    .we_n     (sram_we_n),
    .oe_n     (sram_oe_n),
    .dq_out   (sram_dq_out),
    .dq_oe    (sram_dq_oe)
  );

  assert_done_reopens_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> req_ready);
  assert_take_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_release_with_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> ($past(sram_dq_oe) && !sram_dq_oe));
endmodule

// File: tb/sram_wr_seq_test.sv
`timescale 1ns/1ps
module sram_wr_seq_test;
  localparam int          AW = 8;
  localparam int          DW = 16;
  localparam int unsigned TS = 2;
  localparam int unsigned TO = 3;
  localparam int unsigned TH = 2;
  localparam int unsigned TR = 2;
  localparam int unsigned TOT = TS + 1 + TO + TH + TR;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, wr_done, ce1_n, ce2, we_n, oe_n, dq_oe;
  logic [AW-1:0] sram_addr;
  logic [DW-1:0] dq_out;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] model_mem [0:(1<<AW)-1];
  logic [DW-1:0] exp_mem   [0:(1<<AW)-1];
  logic [AW-1:0] prev_addr;
  logic          prev_we_n;

  always #10 clk = ~clk;

  sram_wr_seq #(.AW(AW), .DW(DW), .T_SETUP(TS), .T_OVERLAP(TO),
                .T_HOLD(TH), .T_RECOV(TR)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .wr_done(wr_done),
    .sram_addr(sram_addr), .sram_ce1_n(ce1_n), .sram_ce2(ce2),
    .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_dq_out(dq_out),
    .sram_dq_oe(dq_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // phase a busy clock belongs to: 1 setup, 2 strobe low, 3 overlap, 4 hold, 5 recovery
  function automatic int phase_at(int i);
    if (i < int'(TS))                return 1;
    if (i == int'(TS))               return 2;
    if (i < int'(TS + 1 + TO))       return 3;
    if (i < int'(TS + 1 + TO + TH))  return 4;
    return 5;
  endfunction

  // RAM model: stores, bus conflicts, address moves under a low strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ce1_n && ce2 && !we_n && dq_oe) model_mem[sram_addr] <= dq_out;
      if (!ce1_n && ce2 && we_n && !oe_n && dq_oe) chk("R6 bus conflict", 1, 0);
      if ((sram_addr != prev_addr) && (!we_n || !prev_we_n))
        chk("R3 address moved with strobe low", 1, 0);
    end
    prev_addr <= sram_addr;
    prev_we_n <= we_n;
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit junk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    for (int i = 0; i < int'(TOT); i++) begin
      int p;
      @(negedge clk);
      p = phase_at(i);
      chk("R2 ready low while busy", req_ready, 0);
      chk(p == 1 ? "R4 setup strobe" : (p == 5 ? "R9 recovery strobe" : "R8 strobe low"),
          we_n, (p == 1 || p == 5));
      chk(p == 3 ? "R7 selects active" : "R5 selects idle", {ce1_n, ce2}, (p == 3) ? 2'b01 : 2'b10);
      chk(p == 4 ? "R8 hold drive" : "R6 bus drive", dq_oe, (p == 3 || p == 4));
      chk("R9 done pulse", wr_done, (i == int'(TOT) - 1));
      chk("R11 output enable", oe_n, 0);
      chk(junk ? "R10 address held" : "R3 address", sram_addr, a);
      if (dq_oe) chk(junk ? "R10 data held" : "R6 data word", dq_out, d);
      if (junk && i < int'(TOT) - 1) begin
        req_valid = 1'($urandom % 2); req_addr = ~a; req_data = ~d;
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    exp_mem[a] = d;
    chk("R9 ready after done", req_ready, 1);
    chk("R3 stored word", model_mem[a], d);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int k = 0; k < (1<<AW); k++) begin model_mem[k] = 'x; exp_mem[k] = 'x; end
    repeat (3) @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset strobe", we_n, 1);
    chk("R1 reset selects", {ce1_n, ce2}, 2'b10);
    chk("R1 reset drive", dq_oe, 0);
    chk("R1 reset done", wr_done, 0);
    chk("R11 reset output enable", oe_n, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset ready", req_ready, 1);
    chk("R1 after reset strobe", we_n, 1);
    // directed corners
    do_write('0, 16'h0000, 1'b0);
    do_write({AW{1'b1}}, 16'hFFFF, 1'b0);
    do_write(8'h5A, 16'hA5C3, 1'b1);
    do_write(8'h5A, 16'h1234, 1'b0);   // overwrite, back to back
    do_write(8'h5A, 16'h8001, 1'b1);
    chk("R3 overwrite keeps last", model_mem[8'h5A], 16'h8001);
    // random traffic
    for (int n = 0; n < 40; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom);
      d = DW'($urandom);
      do_write(a, d, ($urandom % 3) == 0);
      if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
    end
    for (int k = 0; k < (1<<AW); k++)
      if (exp_mem[k] !== 'x) chk("R3 final contents", model_mem[k], exp_mem[k]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule